// File: doc/BRIEF.md
# SECDED Memory with Indirect Test Port

This block holds a small single-port memory whose words are made of four 32-bit lanes. Each lane is guarded by its own single-error-correct, double-error-detect Hamming code with seven check bits. All access goes through a word-wide register bus, which drives an indirect access engine. Software loads an address, the lane data, the check bits and an access mode into registers, then pulses a start bit. The engine performs one memory read or write in a fixed two cycles.

Two override bits control the data path and the check-bit path separately. Software can therefore store a word whose data and check bits disagree. It can also read back the raw stored check bits. The typical sequence is: store a word, capture its check bits, then store altered data with the old check bits. A normal read of that word must return the corrected data and raise the error status.

Corrected reads set sticky single-error and double-error flags and record the failing address. A single-error interrupt is raised while the single-error flag is set and the interrupt is enabled.

Top module: `eccprobe_top`

## Requirements
- R1: After reset every register reads zero, including the busy bit at offset 0x04 and the status at offset 0x05, and `irq` is low.
- R2: A write access (access register 0x03: bit0 direction 1=write, bit1 data override, bit2 check override) with data override set and check override clear stores the lane data with computed check bits. The check bits are computed as follows. Data bit k sits at the k-th position in 1..38 that is not a power of two. The low six check bits are the XOR of the positions of the set data bits. Bit 6 is even parity over data and those six bits (data 0x1 gives 0x43, data 0x2 gives 0x45). A read with check override set copies the stored check bits into register 0x11, with lane n at bits [8n+6:8n].
- R3: With both overrides set, a write stores the lane data (0x08..0x0B) and the check bits (0x10, same packing) exactly as given. A read with data override set returns the stored data unaltered in 0x0C..0x0F and sets no status.
- R4: When ECC is enabled (0x00 bit0) and a stored lane has exactly one flipped bit, in data or in check bits, a read with data override clear returns the corrected data. It sets status bit0 and latches the address into 0x06. Other lanes are unaffected.
- R5: A lane with two flipped bits sets status bit1, does not set bit0, and returns its data uncorrected.
- R6: With ECC disabled, reads return the raw stored data and set no status.
- R7: While the write-enable bit (0x01 bit0) is clear, write accesses leave the memory unchanged.
- R8: Writing 1 to bit0 of 0x04 starts an access. That bit reads 1 for exactly two cycles, and the results are visible once it reads 0.
- R9: A start request that arrives while an access is busy is ignored and launches no further access.
- R10: Status bits are sticky: later clean reads do not clear them. Writing 1 to a status bit clears only that bit.
- R11: `irq` is high exactly while status bit0 is set and the interrupt enable (0x00 bit1) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Single-error interrupt |

## Verification
A register write takes effect at the clock edge that samples the strobe. The access it starts completes at the second edge after that. Memory contents, read registers, status and `irq` are all updated at that completing edge. The bench samples outputs at the falling edge. It waits two falling edges after a start before reading results, and it probes the busy bit at each of the intermediate falling edges.

// File: rtl/eccprobe_pkg.sv
package eccprobe_pkg;
    localparam int WORD_W = 32;
    localparam int CHK_W  = 7;
    localparam int LANES  = 4;
    localparam int SYN_W  = CHK_W - 1;
    localparam int HAM_W  = WORD_W + SYN_W;
    localparam int LANE_W = WORD_W + CHK_W;
    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h00;
    localparam logic [REG_AW-1:0] OFS_WREN  = 5'h01;
    localparam logic [REG_AW-1:0] OFS_ADDR  = 5'h02;
    localparam logic [REG_AW-1:0] OFS_MODE  = 5'h03;
    localparam logic [REG_AW-1:0] OFS_GO    = 5'h04;
    localparam logic [REG_AW-1:0] OFS_STAT  = 5'h05;
    localparam logic [REG_AW-1:0] OFS_EADDR = 5'h06;
    localparam logic [REG_AW-1:0] OFS_WDAT  = 5'h08;
    localparam logic [REG_AW-1:0] OFS_RDAT  = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_WCHK  = 5'h10;
    localparam logic [REG_AW-1:0] OFS_RCHK  = 5'h11;

    // XOR of the code positions of all set data bits
    function automatic logic [SYN_W-1:0] ham_sum(input logic [WORD_W-1:0] d);
        logic [SYN_W-1:0] s;
        int k;
        s = '0;
        k = 0;
        for (int p = 1; p <= HAM_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[k]) s = s ^ p[SYN_W-1:0];
                k++;
            end
        end
        return s;
    endfunction

    function automatic logic [CHK_W-1:0] chk_gen(input logic [WORD_W-1:0] d);
        logic [SYN_W-1:0] s;
        s = ham_sum(d);
        return {(^d) ^ (^s), s};
    endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import eccprobe_pkg::*;
(
    input  logic [WORD_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);
    assign chk = chk_gen(data);
endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import eccprobe_pkg::*;
(
    input  logic [WORD_W-1:0] data,
    input  logic [CHK_W-1:0]  chk,
    output logic [WORD_W-1:0] fixed,
    output logic              one_err,
    output logic              two_err
);
    logic [SYN_W-1:0] syn;
    logic             par;

    always_comb begin
        int k;
        syn   = ham_sum(data) ^ chk[SYN_W-1:0];
        par   = (^data) ^ (^chk);
        fixed = data;
        k     = 0;
        for (int p = 1; p <= HAM_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (par && (syn == p[SYN_W-1:0])) fixed[k] = ~data[k];
                k++;
            end
        end
        one_err = par;
        two_err = !par && (syn != '0);
    end
endmodule

// File: rtl/ecc_store.sv
module ecc_store #(
    parameter int ADDR_W = 4,
    parameter int W      = 156
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end
    assign rdata = mem[addr];
endmodule

// File: rtl/eccprobe_top.sv
module eccprobe_top
    import eccprobe_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int MEM_W = LANES * LANE_W;

    typedef struct packed {
        logic                         ecc_on;
        logic                         irq_en;
        logic                         wr_en;
        logic [ADDR_W-1:0]            addr;
        logic                         dir;
        logic                         dovr;
        logic                         eovr;
        logic                         busy;
        logic                         last;
        logic [LANES-1:0][WORD_W-1:0] wdat;
        logic [LANES-1:0][CHK_W-1:0]  wchk;
        logic [LANES-1:0][WORD_W-1:0] rdat;
        logic [LANES-1:0][CHK_W-1:0]  rchk;
        logic                         sbe;
        logic                         dbe;
        logic [ADDR_W-1:0]            err_addr;
    } state_t;

    state_t st_d, st_q;

    logic [MEM_W-1:0]             mem_rd, mem_wdata;
    logic                         mem_we;
    logic [LANES-1:0][WORD_W-1:0] raw_d, fix_d, enc_in;
    logic [LANES-1:0][CHK_W-1:0]  raw_c, enc_c;
    logic [LANES-1:0]             lane_sbe, lane_dbe;

    // signals observed by the bound checker
    logic acc_busy, acc_last, wr_en_q, sbe_flag, dbe_flag;
    assign acc_busy = st_q.busy;
    assign acc_last = st_q.last;
    assign wr_en_q  = st_q.wr_en;
    assign sbe_flag = st_q.sbe;
    assign dbe_flag = st_q.dbe;

    ecc_store #(.ADDR_W(ADDR_W), .W(MEM_W)) store_i (
        .clk   (clk),
        .we    (mem_we),
        .addr  (st_q.addr),
        .wdata (mem_wdata),
        .rdata (mem_rd)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign raw_d[l]  = mem_rd[l*LANE_W +: WORD_W];
        assign raw_c[l]  = mem_rd[l*LANE_W+WORD_W +: CHK_W];
        assign enc_in[l] = st_q.dovr ? st_q.wdat[l] : raw_d[l];

        secded_enc enc_i (
            .data (enc_in[l]),
            .chk  (enc_c[l])
        );

        secded_dec dec_i (
            .data    (raw_d[l]),
            .chk     (raw_c[l]),
            .fixed   (fix_d[l]),
            .one_err (lane_sbe[l]),
            .two_err (lane_dbe[l])
        );

        assign mem_wdata[l*LANE_W +: LANE_W] =
            {st_q.eovr ? st_q.wchk[l] : enc_c[l], enc_in[l]};
    end

    always_comb begin
        logic commit;
        st_d   = st_q;
        mem_we = 1'b0;
        commit = st_q.busy && st_q.last;

        if (reg_we) begin
            if (reg_addr[4:2] == OFS_WDAT[4:2]) begin
                st_d.wdat[reg_addr[1:0]] = reg_wdata;
            end else begin
                case (reg_addr)
                    OFS_CTRL: begin
                        st_d.ecc_on = reg_wdata[0];
                        st_d.irq_en = reg_wdata[1];
                    end
                    OFS_WREN: st_d.wr_en = reg_wdata[0];
                    OFS_ADDR: st_d.addr  = reg_wdata[ADDR_W-1:0];
                    OFS_MODE: begin
                        st_d.dir  = reg_wdata[0];
                        st_d.dovr = reg_wdata[1];
                        st_d.eovr = reg_wdata[2];
                    end
                    OFS_GO: begin
                        if (reg_wdata[0] && !st_q.busy) begin
                            st_d.busy = 1'b1;
                            st_d.last = 1'b0;
                        end
                    end
                    OFS_STAT: begin
                        if (reg_wdata[0]) st_d.sbe = 1'b0;
                        if (reg_wdata[1]) st_d.dbe = 1'b0;
                    end
                    OFS_WCHK: begin
                        for (int l = 0; l < LANES; l++)
                            st_d.wchk[l] = reg_wdata[l*8 +: CHK_W];
                    end
                    default: ;
                endcase
            end
        end

        if (st_q.busy && !st_q.last) st_d.last = 1'b1;

        if (commit) begin
            st_d.busy = 1'b0;
            st_d.last = 1'b0;
            if (st_q.dir) begin
                mem_we = st_q.wr_en;
            end else begin
                for (int l = 0; l < LANES; l++) begin
                    st_d.rdat[l] = (st_q.dovr || !st_q.ecc_on) ? raw_d[l] : fix_d[l];
                    if (st_q.eovr) st_d.rchk[l] = raw_c[l];
                end
                if (st_q.ecc_on && !st_q.dovr && (|lane_sbe || |lane_dbe)) begin
                    if (|lane_sbe) st_d.sbe = 1'b1;
                    if (|lane_dbe) st_d.dbe = 1'b1;
                    st_d.err_addr = st_q.addr;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[4:2] == OFS_WDAT[4:2]) begin
            reg_rdata = st_q.wdat[reg_addr[1:0]];
        end else if (reg_addr[4:2] == OFS_RDAT[4:2]) begin
            reg_rdata = st_q.rdat[reg_addr[1:0]];
        end else begin
            case (reg_addr)
                OFS_CTRL:  reg_rdata = {30'd0, st_q.irq_en, st_q.ecc_on};
                OFS_WREN:  reg_rdata = {31'd0, st_q.wr_en};
                OFS_ADDR:  reg_rdata = 32'(st_q.addr);
                OFS_MODE:  reg_rdata = {29'd0, st_q.eovr, st_q.dovr, st_q.dir};
                OFS_GO:    reg_rdata = {31'd0, st_q.busy};
                OFS_STAT:  reg_rdata = {30'd0, st_q.dbe, st_q.sbe};
                OFS_EADDR: reg_rdata = 32'(st_q.err_addr);
                OFS_WCHK: begin
                    for (int l = 0; l < LANES; l++) reg_rdata[l*8 +: CHK_W] = st_q.wchk[l];
                end
                OFS_RCHK: begin
                    for (int l = 0; l < LANES; l++) reg_rdata[l*8 +: CHK_W] = st_q.rchk[l];
                end
                default: reg_rdata = '0;
            endcase
        end
    end

    assign irq = st_q.sbe && st_q.irq_en;
endmodule

// File: rtl/eccprobe_chk.sv
module eccprobe_chk
    import eccprobe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              acc_busy,
    input logic              acc_last,
    input logic              mem_we,
    input logic              wr_en_q,
    input logic [LANES-1:0]  lane_sbe,
    input logic [LANES-1:0]  lane_dbe,
    input logic              sbe_flag,
    input logic              dbe_flag,
    input logic              irq
);
    assert_busy_two_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_busy) |=> (acc_busy && acc_last));

    assert_no_relaunch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_busy && acc_last) |=> !acc_busy);

    assert_we_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wr_en_q && acc_busy && acc_last));

    assert_lane_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sbe & lane_dbe) == '0);

    assert_sbe_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_flag && !(reg_we && reg_addr == OFS_STAT && reg_wdata[0])) |=> sbe_flag);

    assert_dbe_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dbe_flag && !(reg_we && reg_addr == OFS_STAT && reg_wdata[1])) |=> dbe_flag);

    assert_irq_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> sbe_flag);
endmodule

bind eccprobe_top eccprobe_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .acc_busy  (acc_busy),
    .acc_last  (acc_last),
    .mem_we    (mem_we),
    .wr_en_q   (wr_en_q),
    .lane_sbe  (lane_sbe),
    .lane_dbe  (lane_dbe),
    .sbe_flag  (sbe_flag),
    .dbe_flag  (dbe_flag),
    .irq       (irq)
);

// File: tb/eccprobe_top_tb_top.sv
module eccprobe_top_tb_top;
    import eccprobe_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    eccprobe_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic [31:0] val;
        logic [31:0] flip;
        logic        dbe;
        logic        sbe;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0001, 32'h0000_0000, 1'b0, 1'b0},
        '{32'hDEAD_BEEF, 32'h0000_0001, 1'b0, 1'b1},
        '{32'h1234_5678, 32'h8000_0000, 1'b0, 1'b1},
        '{32'hA5A5_A5A5, 32'h0000_2000, 1'b0, 1'b1},
        '{32'hFFFF_0000, 32'h0000_0003, 1'b1, 1'b0},
        '{32'h0F0F_0F0F, 32'h8000_0001, 1'b1, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic go();
        wr(OFS_GO, 32'd1);
        repeat (2) @(negedge clk);
    endtask

    task automatic access(input logic [2:0] mode);
        wr(OFS_MODE, {29'd0, mode});
        go();
    endtask

    logic done = 1'b0;

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c;
        repeat (3) @(negedge clk);
        rd(OFS_CTRL, v);  check("R1 ctrl", v, 32'd0);
        rd(OFS_GO, v);    check("R1 busy", v, 32'd0);
        rd(OFS_STAT, v);  check("R1 status", v, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        rd(OFS_RCHK, v);  check("R1 rchk", v, 32'd0);

        // R2: encoding of known values
        wr(OFS_WREN, 32'd1);
        wr(OFS_ADDR, 32'd0);
        wr(OFS_WDAT + 5'd0, 32'h1);
        wr(OFS_WDAT + 5'd1, 32'h2);
        wr(OFS_WDAT + 5'd2, 32'h0);
        wr(OFS_WDAT + 5'd3, 32'h0);
        access(3'b011);
        access(3'b100);
        rd(OFS_RCHK, v);  check("R2 computed check bits", v, 32'h0000_4543);

        // R3: both overrides store verbatim, raw read returns them
        for (int l = 0; l < 4; l++) wr(OFS_WDAT + 5'(l), 32'hCAFE_F000 + 32'(l));
        wr(OFS_WCHK, 32'h7F55_2A01);
        access(3'b111);
        wr(OFS_CTRL, 32'd1);
        access(3'b110);
        rd(OFS_RDAT + 5'd0, v); check("R3 raw data lane0", v, 32'hCAFE_F000);
        rd(OFS_RDAT + 5'd3, v); check("R3 raw data lane3", v, 32'hCAFE_F003);
        rd(OFS_RCHK, v);        check("R3 raw check bits", v, 32'h7F55_2A01);
        rd(OFS_STAT, v);        check("R3 no status on raw read", v, 32'd0);

        // R7: write blocked while write enable clear
        wr(OFS_WREN, 32'd0);
        wr(OFS_WDAT + 5'd0, 32'h0);
        access(3'b011);
        wr(OFS_WREN, 32'd1);
        access(3'b010);
        rd(OFS_RDAT + 5'd0, v); check("R7 memory unchanged", v, 32'hCAFE_F000);

        // R8: busy for exactly two cycles
        wr(OFS_GO, 32'd1);
        rd(OFS_GO, v); check("R8 busy cycle 1", v, 32'd1);
        @(negedge clk); rd(OFS_GO, v); check("R8 busy cycle 2", v, 32'd1);
        @(negedge clk); rd(OFS_GO, v); check("R8 idle after two", v, 32'd0);

        // R9: start while busy is ignored
        wr(OFS_GO, 32'd1);
        wr(OFS_GO, 32'd1);
        rd(OFS_GO, v); check("R9 done despite second start", v, 32'd0);
        @(negedge clk); rd(OFS_GO, v); check("R9 no relaunch", v, 32'd0);

        // table of injected-error vectors (R4, R5), ECC on, irq disabled
        for (int i = 0; i < NV; i++) begin
            wr(OFS_ADDR, 32'(i + 1));
            wr(OFS_WDAT + 5'd0, VECS[i].val);
            wr(OFS_WDAT + 5'd1, 32'h1111_1111);
            wr(OFS_WDAT + 5'd2, 32'h2222_2222);
            wr(OFS_WDAT + 5'd3, 32'h3333_3333);
            access(3'b011);
            access(3'b100);
            rd(OFS_RCHK, c);
            wr(OFS_WCHK, c);
            wr(OFS_WDAT + 5'd0, VECS[i].val ^ VECS[i].flip);
            access(3'b111);
            wr(OFS_STAT, 32'd3);
            access(3'b000);
            rd(OFS_RDAT + 5'd0, v);
            if (VECS[i].dbe) check("R5 uncorrected data", v, VECS[i].val ^ VECS[i].flip);
            else             check("R4 corrected data", v, VECS[i].val);
            rd(OFS_RDAT + 5'd1, v); check("R4 other lane intact", v, 32'h1111_1111);
            rd(OFS_STAT, v);
            check(VECS[i].dbe ? "R5 status" : "R4 status", v, {30'd0, VECS[i].dbe, VECS[i].sbe});
            if (VECS[i].dbe || VECS[i].sbe) begin
                rd(OFS_EADDR, v); check("R4 error address", v, 32'(i + 1));
            end
            check("R11 irq off while disabled", {31'd0, irq}, 32'd0);
        end

        // R4: flipped check bit, data intact
        wr(OFS_ADDR, 32'd9);
        wr(OFS_WDAT + 5'd0, 32'h5555_AAAA);
        access(3'b011);
        access(3'b100);
        rd(OFS_RCHK, c);
        wr(OFS_WCHK, c ^ 32'h0000_0004);
        access(3'b111);
        wr(OFS_STAT, 32'd3);
        access(3'b000);
        rd(OFS_RDAT + 5'd0, v); check("R4 check-bit flip data", v, 32'h5555_AAAA);
        rd(OFS_STAT, v);        check("R4 check-bit flip status", v, 32'd1);

        // R6: ECC off returns raw, no status
        wr(OFS_STAT, 32'd3);
        wr(OFS_CTRL, 32'd0);
        wr(OFS_ADDR, 32'd2);
        access(3'b000);
        rd(OFS_RDAT + 5'd0, v); check("R6 raw data", v, 32'hDEAD_BEEE);
        rd(OFS_STAT, v);        check("R6 no status", v, 32'd0);

        // R10 / R11
        wr(OFS_CTRL, 32'd3);
        access(3'b000);
        check("R11 irq raised", {31'd0, irq}, 32'd1);
        wr(OFS_STAT, 32'd2);
        rd(OFS_STAT, v); check("R10 clear other bit keeps sbe", v, 32'd1);
        wr(OFS_ADDR, 32'd1);
        access(3'b000);
        rd(OFS_STAT, v); check("R10 sticky after clean read", v, 32'd1);
        wr(OFS_CTRL, 32'd1);
        check("R11 irq masked", {31'd0, irq}, 32'd0);
        wr(OFS_CTRL, 32'd3);
        wr(OFS_STAT, 32'd1);
        rd(OFS_STAT, v); check("R10 cleared by write one", v, 32'd0);
        check("R11 irq dropped", {31'd0, irq}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule